// File: doc/BRIEF.md
# Step Clock Input Conditioner

This block takes the asynchronous control pins of a stepper sequencer and turns them into clean, synchronous events. The step clock and the return-to-origin input are each brought into the system clock domain through a two-flop synchronizer. Each then passes through an agreement filter. The filter accepts a new level only after it has been seen for `FILT_N` consecutive samples, so short noise pulses are dropped. A synchronized edge-select input picks whether only rising step edges count or both edges count. Every accepted edge yields a one-cycle step strobe.

Direction and the excitation-mode bits are synchronized but not filtered. The system keeps them still in a guard window around each step edge, and they are copied into holding registers only in the cycle just before a step strobe. They are never picked up between steps. When the newly captured mode differs from the one held before, a one-cycle mode-switch strobe is raised in that same cycle, one cycle before the step it belongs to. A filtered low-to-high change of the return input gives a one-cycle return strobe.

Pulling the enable input low freezes every register. Only the reset can then change the block's state, and all strobes stay low.

Top module: `step_input_conditioner`

## Requirements
- R1: While reset is asserted (rst_n low), step_stb, mode_stb and ret_stb are 0, dir_q is 0 and mode_q is all zeros.
- R2: A step pin level that lasts fewer than FILT_N system clock cycles is rejected and yields no strobe. A level that lasts FILT_N cycles or longer is accepted.
- R3: An accepted step edge makes step_stb high in the cycle that starts FILT_N+4 rising edges after the clock edge just before the pin changed.
- R4: With edge_both_raw = 0, only accepted low-to-high step edges give a strobe. With edge_both_raw = 1, accepted edges of either polarity each give one strobe.
- R5: dir_q and mode_q take the values the dir_raw and mode_raw pins held during the guard window, and they change in the cycle just before the step strobe.
- R6: mode_stb is high for one cycle, one cycle before step_stb, exactly when the newly captured mode differs from the previously held mode_q. Otherwise it stays low.
- R7: Changes on dir_raw and mode_raw with no step edge have no effect on dir_q, mode_q or mode_stb.
- R8: An accepted low-to-high change of ret_raw makes ret_stb high in the cycle that starts FILT_N+3 rising edges after the clock edge just before the pin changed. Falling edges, and pulses shorter than FILT_N cycles, give no return strobe.
- R9: While en is low, no strobe is raised and dir_q and mode_q hold. Pin activity that returns to the prior levels before en rises again causes nothing after re-enable.
- R10: Each strobe (step_stb, mode_stb, ret_stb) is high for a single cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock enable; low freezes all state |
| step_raw | input | 1 | Asynchronous step clock pin |
| dir_raw | input | 1 | Asynchronous direction pin |
| mode_raw | input | MODE_W | Asynchronous excitation-mode pins |
| edge_both_raw | input | 1 | 0: rising step edges only; 1: both edges |
| ret_raw | input | 1 | Asynchronous return-to-origin pin |
| step_stb | output | 1 | One-cycle step strobe |
| mode_stb | output | 1 | One-cycle mode-switch strobe, one cycle before step_stb |
| dir_q | output | 1 | Direction latched at the last step |
| mode_q | output | MODE_W | Mode latched at the last step |
| ret_stb | output | 1 | One-cycle return strobe |

## Verification
The bench drives pins on the falling clock edge and counts rising edges. For a pin change made when that count is C, the mode-switch strobe and the new dir_q and mode_q values are due when the count is C+FILT_N+3. The step strobe is due one count later, at C+FILT_N+4, and the return strobe is due at C+FILT_N+3. A monitor on the falling edge records the count at which each strobe was seen, along with the latched outputs at that moment. Each check compares those recorded counts against the bench's own arithmetic on the toggle count. Glitch, idle and disabled phases are checked by comparing strobe tallies after a settle time of well over FILT_N+4 cycles.

// File: rtl/step_input_conditioner.sv
module step_input_conditioner #(
  parameter int FILT_N = 4,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              step_raw,
  input  logic              dir_raw,
  input  logic [MODE_W-1:0] mode_raw,
  input  logic              edge_both_raw,
  input  logic              ret_raw,
  output logic              step_stb,
  output logic              mode_stb,
  output logic              dir_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              ret_stb
);
  localparam int CW  = (FILT_N > 2) ? $clog2(FILT_N) : 1;
  localparam int NCH = 2;
  localparam int SW  = MODE_W + 2;

  wire  [NCH-1:0] raw_f = {ret_raw, step_raw};
  wire  [SW-1:0]  raw_u = {edge_both_raw, dir_raw, mode_raw};
  logic [NCH-1:0] lvl, lvl_d;
  logic [SW-1:0]  s1, s2;
  logic           pend;

  for (genvar g = 0; g < NCH; g++) begin : g_filt
    logic [1:0]    sync;
    logic [CW-1:0] cnt;
    logic          lvl_g;
    assign lvl[g] = lvl_g;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync  <= '0;
        cnt   <= '0;
        lvl_g <= 1'b0;
      end else if (en) begin
        sync <= {sync[0], raw_f[g]};
        if (sync[1] == lvl_g) begin
          cnt <= '0;
        end else if (cnt == CW'(FILT_N - 1)) begin
          cnt   <= '0;
          lvl_g <= sync[1];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  wire [MODE_W-1:0] mode_s = s2[MODE_W-1:0];
  wire              dir_s  = s2[MODE_W];
  wire              both_s = s2[MODE_W+1];
  wire              evt    = both_s ? (lvl[0] ^ lvl_d[0]) : (lvl[0] & ~lvl_d[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1       <= '0;
      s2       <= '0;
      lvl_d    <= '0;
      pend     <= 1'b0;
      step_stb <= 1'b0;
      mode_stb <= 1'b0;
      ret_stb  <= 1'b0;
      dir_q    <= 1'b0;
      mode_q   <= '0;
    end else if (!en) begin
      step_stb <= 1'b0;
      mode_stb <= 1'b0;
      ret_stb  <= 1'b0;
    end else begin
      s1       <= raw_u;
      s2       <= s1;
      lvl_d    <= lvl;
      pend     <= evt;
      step_stb <= pend;
      mode_stb <= evt && (mode_s != mode_q);
      ret_stb  <= lvl[1] & ~lvl_d[1];
      if (evt) begin
        dir_q  <= dir_s;
        mode_q <= mode_s;
      end
    end
  end
endmodule

// File: rtl/step_cond_chk.sv
module step_cond_chk #(
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              step_stb,
  input logic              mode_stb,
  input logic              dir_q,
  input logic [MODE_W-1:0] mode_q,
  input logic              ret_stb
);
  // R10
  step_single_chk: assert property (@(posedge clk) disable iff (!rst_n) step_stb |=> !step_stb);
  // R10
  ret_single_chk: assert property (@(posedge clk) disable iff (!rst_n) ret_stb |=> !ret_stb);
  // R6
  mode_before_step_chk: assert property (@(posedge clk) disable iff (!rst_n) (mode_stb && en) |=> step_stb);
  // R5
  dir_before_step_chk: assert property (@(posedge clk) disable iff (!rst_n) (!$stable(dir_q) && en) |=> step_stb);
  // R5
  mode_latch_step_chk: assert property (@(posedge clk) disable iff (!rst_n) (!$stable(mode_q) && en) |=> step_stb);
  // R9
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> (!step_stb && !mode_stb && !ret_stb));
  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> ($stable(dir_q) && $stable(mode_q)));
endmodule

bind step_input_conditioner step_cond_chk #(.MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .step_stb(step_stb), .mode_stb(mode_stb),
  .dir_q(dir_q), .mode_q(mode_q), .ret_stb(ret_stb)
);

// File: tb/sim_step_input_conditioner.sv
module sim_step_input_conditioner;
  localparam int N = 4;
  logic clk = 0, rst_n = 0, en = 1;
  logic step_raw = 0, dir_raw = 0, edge_both_raw = 0, ret_raw = 0;
  logic [1:0] mode_raw = 0;
  logic step_stb, mode_stb, dir_q, ret_stb;
  logic [1:0] mode_q;

  step_input_conditioner #(.FILT_N(N), .MODE_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .step_raw(step_raw), .dir_raw(dir_raw),
    .mode_raw(mode_raw), .edge_both_raw(edge_both_raw), .ret_raw(ret_raw),
    .step_stb(step_stb), .mode_stb(mode_stb), .dir_q(dir_q), .mode_q(mode_q), .ret_stb(ret_stb));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int step_cnt = 0, mstb_cnt = 0, ret_cnt = 0, dbl = 0;
  int last_step = -1, last_mstb = -1, last_ret = -1;
  logic last_dir = 0;
  logic [1:0] last_mode = 0;
  logic p_step = 0, p_mode = 0, p_ret = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (step_stb) begin step_cnt++; last_step = cyc; last_dir = dir_q; last_mode = mode_q; end
      if (mode_stb) begin mstb_cnt++; last_mstb = cyc; end
      if (ret_stb) begin ret_cnt++; last_ret = cyc; end
      if ((step_stb && p_step) || (mode_stb && p_mode) || (ret_stb && p_ret)) dbl++;
    end
    p_step = step_stb; p_mode = mode_stb; p_ret = ret_stb;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit exp_fire(input bit both, input bit new_lvl);
    return both || new_lvl;
  endfunction

  logic       m_dir = 0;
  logic [1:0] m_mode = 0;

  task automatic edge_test(input string req);
    int b, bm, t0;
    bit f, mchg;
    b = step_cnt; bm = mstb_cnt;
    @(negedge clk); t0 = cyc; step_raw = ~step_raw;
    f = exp_fire(edge_both_raw, step_raw);
    mchg = f && (mode_raw != m_mode);
    wait_n(14);
    chk(step_cnt == b + int'(f), req, step_cnt - b, int'(f));
    if (f) begin
      chk(last_step == t0 + N + 4, "R3", last_step, t0 + N + 4);
      chk(last_dir == dir_raw, "R5", last_dir, dir_raw);
      chk(last_mode == mode_raw, "R5", last_mode, mode_raw);
      chk(mstb_cnt == bm + int'(mchg), "R6", mstb_cnt - bm, int'(mchg));
      if (mchg) chk(last_mstb == t0 + N + 3, "R6", last_mstb, t0 + N + 3);
      m_dir = dir_raw; m_mode = mode_raw;
    end else begin
      chk(mstb_cnt == bm, "R6", mstb_cnt - bm, 0);
    end
  endtask

  task automatic glitch_test(input int w, input string req);
    int b;
    b = step_cnt;
    @(negedge clk); step_raw = ~step_raw;
    wait_n(w);
    step_raw = ~step_raw;
    wait_n(16);
    chk(step_cnt == b, req, step_cnt - b, 0);
  endtask

  initial begin
    int b, t0;
    void'($urandom(32'h5eed_0042));
    wait_n(3);
    chk(!step_stb && !mode_stb && !ret_stb, "R1", {step_stb, mode_stb, ret_stb}, 0);
    chk(dir_q == 0 && mode_q == 0, "R1", {dir_q, mode_q}, 0);
    rst_n = 1;
    wait_n(4);

    // R2: glitch one short of the filter depth, then exactly the filter depth
    edge_both_raw = 1; wait_n(4);
    glitch_test(N - 1, "R2");
    b = step_cnt;
    @(negedge clk); t0 = cyc; step_raw = 1;
    wait_n(N); step_raw = 0;
    wait_n(16);
    chk(step_cnt == b + 2, "R2", step_cnt - b, 2);
    chk(last_step == t0 + 2 * N + 4, "R2", last_step, t0 + 2 * N + 4);

    // R4: rising-only ignores falling edge
    edge_both_raw = 0; dir_raw = 1; mode_raw = 2'd3; wait_n(6);
    edge_test("R4");
    edge_test("R4");

    // R7: dir/mode moves without a step
    dir_raw = ~m_dir; mode_raw = m_mode + 2'd1; b = mstb_cnt;
    wait_n(20);
    chk(dir_q == m_dir, "R7", dir_q, m_dir);
    chk(mode_q == m_mode, "R7", mode_q, m_mode);
    chk(mstb_cnt == b, "R7", mstb_cnt - b, 0);

    // R8: return strobe
    b = ret_cnt;
    @(negedge clk); t0 = cyc; ret_raw = 1;
    wait_n(14);
    chk(ret_cnt == b + 1, "R8", ret_cnt - b, 1);
    chk(last_ret == t0 + N + 3, "R8", last_ret, t0 + N + 3);
    ret_raw = 0; wait_n(14);
    chk(ret_cnt == b + 1, "R8", ret_cnt - b, 1);
    @(negedge clk); ret_raw = 1; wait_n(N - 1); ret_raw = 0; wait_n(14);
    chk(ret_cnt == b + 1, "R8", ret_cnt - b, 1);

    // R9: enable low freezes state
    edge_both_raw = 1; dir_raw = m_dir; mode_raw = m_mode; wait_n(6);
    b = step_cnt + ret_cnt + mstb_cnt;
    @(negedge clk); en = 0;
    wait_n(2); step_raw = ~step_raw; ret_raw = 1; dir_raw = ~m_dir; mode_raw = ~m_mode;
    wait_n(12); step_raw = ~step_raw; ret_raw = 0;
    wait_n(6);
    chk(step_cnt + ret_cnt + mstb_cnt == b, "R9", step_cnt + ret_cnt + mstb_cnt - b, 0);
    chk(dir_q == m_dir && mode_q == m_mode, "R9", {dir_q, mode_q}, {m_dir, m_mode});
    @(negedge clk); en = 1;
    wait_n(20);
    chk(step_cnt + ret_cnt + mstb_cnt == b, "R9", step_cnt + ret_cnt + mstb_cnt - b, 0);
    dir_raw = m_dir; mode_raw = m_mode; wait_n(4);

    // random mix
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      dir_raw = 1'($urandom);
      mode_raw = 2'($urandom);
      if ($urandom % 4 == 0) edge_both_raw = ~edge_both_raw;
      wait_n(6);
      if ($urandom % 4 == 0) glitch_test(1 + int'($urandom % (N - 1)), "R2");
      else edge_test("R4");
    end

    chk(dbl == 0, "R10", dbl, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule